// File: doc/BRIEF.md
# Wide Register Byte Access Bridge

This block lets an 8-bit processor data bus read and write four 16-bit timer registers: a free-running counter, two compare registers and a capture register. A 16-bit value cannot cross an 8-bit bus in one transfer. The bridge therefore keeps one 8-bit holding byte, and all four registers share it. That byte makes every 16-bit transfer appear atomic to software.

To write a register, software first writes its upper half. That write lands only in the holding byte. Software then writes the lower half, and the full 16-bit value reaches the target on that same clock edge. To read the counter or the capture register, software first reads the lower half. That read freezes the matching upper half in the holding byte, where a later read of the upper half finds it. The compare registers do not use the holding byte when read: both of their halves are returned directly. A small up-counter model with clear and count-enable inputs shows that a processor write beats any counting activity. A capture event input copies the counter into the capture register.

Top module: `wide_reg_bridge`

## Requirements
- R1: An asynchronous low level on `rst_n` clears the holding byte, the counter, both compare registers and the capture register at once. Release of the reset takes effect internally after two rising clock edges.
- R2: A write to an upper-half address (`addr[0]`=1) changes only the holding byte. No target register changes, and `ld_stb` stays all-zero in that cycle.
- R3: A write to a lower-half address (`addr[0]`=0) loads the selected register with {holding byte, `wdata`} at that clock edge. In the same cycle it raises `ld_stb` bit `addr[2:1]` with `ld_data` = {holding byte, `wdata`}, and it leaves the holding byte unchanged. One upper-half write therefore serves several later lower-half writes.
- R4: A read (with `wr_en` low) of the lower half of the counter or the capture register returns bits 7:0 of that register on `rdata` in that cycle. At that edge it copies bits 15:8 of the register into the holding byte.
- R5: A read of either compare register returns its bits 7:0 at the lower-half address and its bits 15:8 at the upper-half address. The read never changes the holding byte.
- R6: A read of the upper half of the counter or the capture register returns the holding byte, not the live register.
- R7: The counter follows this priority: a processor lower-half write, then `cnt_clr` (load zero), then `cnt_en` (add one, wrapping from 0xFFFF to 0x0000).
- R8: `cap_evt` copies the counter's value from before that edge into the capture register. A processor lower-half write to the capture register in the same cycle takes priority.
- R9: `rdata` is 0x00 while `rd_en` is low. When `wr_en` and `rd_en` are both high, the write alone decides the holding byte. `rdata` still shows the read.
- R10: The address map is fixed. `addr[2:1]` selects the target: 0 counter, 1 compare A, 2 compare B, 3 capture. `addr[0]` selects the half: 0 lower, 1 upper. At most one `ld_stb` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Target select (bits 2:1) and half select (bit 0) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational |
| cnt_en | input | 1 | Counter increment enable |
| cnt_clr | input | 1 | Counter clear |
| cap_evt | input | 1 | Capture event |
| ld_stb | output | 4 | Per-target 16-bit load strobe, bit index = target code |
| ld_data | output | 16 | Value carried by a 16-bit load |
| cnt_q | output | 16 | Counter value |
| cmpa_q | output | 16 | Compare register A |
| cmpb_q | output | 16 | Compare register B |
| cap_q | output | 16 | Capture register |

## Verification
The holding byte is the only hidden state, and a wrong value in it shows at the ports at the next lower-half write, where the wrong upper half appears on `ld_data` within the same cycle. It also shows at the next upper-half read of the counter or capture register. A stale snapshot, or a compare read that disturbed the byte, therefore shows as a wrong upper half within one or two bus accesses. Faults in priority or wrap appear on the register outputs one edge after the cycle that caused them. The bench compares every output against a behavioural model on every clock.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

  typedef enum logic [1:0] {
    TGT_CNT  = 2'd0,
    TGT_CMPA = 2'd1,
    TGT_CMPB = 2'd2,
    TGT_CAP  = 2'd3
  } tgt_e;

  localparam int NUM_TGT = 4;

  // Targets whose upper half is read straight from the register.
  function automatic logic reads_direct(tgt_e t);
    return (t == TGT_CMPA) || (t == TGT_CMPB);
  endfunction

endpackage

// File: rtl/wrb_rst_sync.sv
module wrb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wrb_decode.sv
module wrb_decode
  import wrb_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic               rd_en,
  output tgt_e               tgt,
  output logic               wr_hi,
  output logic               wr_lo,
  output logic               rd_snap,
  output logic [NUM_TGT-1:0] ld_stb
);
  logic half_hi;

  always_comb begin
    tgt     = tgt_e'(addr[2:1]);
    half_hi = addr[0];
    wr_hi   = wr_en & half_hi;
    wr_lo   = wr_en & ~half_hi;
    rd_snap = rd_en & ~wr_en & ~half_hi & ~reads_direct(tgt);
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_stb
    assign ld_stb[g] = wr_lo & (addr[2:1] == g[1:0]);
  end
endmodule

// File: rtl/wrb_temp.sv
module wrb_temp #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd_snap,
  input  logic [BYTE_W-1:0] snap_byte,
  output logic [BYTE_W-1:0] tmp_q
);
  logic              tmp_en;
  logic [BYTE_W-1:0] tmp_d;

  always_comb begin
    tmp_en = wr_hi | rd_snap;
    if (wr_hi) tmp_d = wdata;
    else       tmp_d = snap_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmp_q <= '0;
    else if (tmp_en) tmp_q <= tmp_d;
  end
endmodule

// File: rtl/wrb_counter.sv
module wrb_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_q
);
  logic         cnt_en;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_en = ld | clr | inc;
    if (ld)       cnt_d = ld_val;
    else if (clr) cnt_d = '0;
    else          cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wrb_hold.sv
module wrb_hold #(
  parameter int W           = 16,
  parameter bit HAS_CAPTURE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         cap_evt,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] q
);
  logic         hold_en;
  logic [W-1:0] hold_d;
  logic         cap_take;

  if (HAS_CAPTURE) begin : g_cap
    assign cap_take = cap_evt;
  end else begin : g_nocap
    assign cap_take = 1'b0;
  end

  always_comb begin
    hold_en = ld | cap_take;
    if (ld) hold_d = ld_val;
    else    hold_d = cap_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (hold_en) q <= hold_d;
  end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wrb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   rdata,
  input  logic                cnt_en,
  input  logic                cnt_clr,
  input  logic                cap_evt,
  output logic [NUM_TGT-1:0]  ld_stb,
  output logic [2*BYTE_W-1:0] ld_data,
  output logic [2*BYTE_W-1:0] cnt_q,
  output logic [2*BYTE_W-1:0] cmpa_q,
  output logic [2*BYTE_W-1:0] cmpb_q,
  output logic [2*BYTE_W-1:0] cap_q
);
  localparam int WIDE_W = 2 * BYTE_W;

  logic              rst_sync_n;
  tgt_e              tgt;
  logic              wr_hi, wr_lo, rd_snap;
  logic [BYTE_W-1:0] tmp_q;
  logic [WIDE_W-1:0] sel_q;
  logic [WIDE_W-1:0] regs_q [NUM_TGT];

  wrb_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  wrb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .tgt(tgt),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .rd_snap(rd_snap), .ld_stb(ld_stb)
  );

  assign ld_data = {tmp_q, wdata};

  wrb_temp #(.BYTE_W(BYTE_W)) u_tmp (
    .clk(clk), .rst_n(rst_sync_n), .wr_hi(wr_hi), .wdata(wdata),
    .rd_snap(rd_snap), .snap_byte(sel_q[WIDE_W-1:BYTE_W]), .tmp_q(tmp_q)
  );

  wrb_counter #(.W(WIDE_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .ld(ld_stb[TGT_CNT]), .ld_val(ld_data),
    .clr(cnt_clr), .inc(cnt_en), .cnt_q(regs_q[TGT_CNT])
  );

  for (genvar g = 1; g < NUM_TGT; g++) begin : g_hold
    wrb_hold #(.W(WIDE_W), .HAS_CAPTURE(g == int'(TGT_CAP))) u_hold (
      .clk(clk), .rst_n(rst_sync_n), .ld(ld_stb[g]), .ld_val(ld_data),
      .cap_evt(cap_evt), .cap_val(regs_q[TGT_CNT]), .q(regs_q[g])
    );
  end

  always_comb begin
    sel_q = regs_q[tgt];
    if (!rd_en)              rdata = '0;
    else if (!addr[0])       rdata = sel_q[BYTE_W-1:0];
    else if (reads_direct(tgt)) rdata = sel_q[WIDE_W-1:BYTE_W];
    else                     rdata = tmp_q;
  end

  assign cnt_q  = regs_q[TGT_CNT];
  assign cmpa_q = regs_q[TGT_CMPA];
  assign cmpb_q = regs_q[TGT_CMPB];
  assign cap_q  = regs_q[TGT_CAP];
endmodule

// File: rtl/wrb_checker.sv
module wrb_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic [2:0]          addr,
  input logic                wr_en,
  input logic                rd_en,
  input logic [BYTE_W-1:0]   wdata,
  input logic [BYTE_W-1:0]   rdata,
  input logic [3:0]          ld_stb,
  input logic [BYTE_W-1:0]   tmp_q,
  input logic [2*BYTE_W-1:0] cnt_q,
  input logic [2*BYTE_W-1:0] cmpa_q
);
  AST_LD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(ld_stb)); // R10
  AST_HI_WRITE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr[0]) |-> (ld_stb == 4'b0000)); // R2
  AST_HI_WRITE_HOLDS_CMPA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr[0]) |=> $stable(cmpa_q)); // R2
  AST_CMPA_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == 3'd2) |=> (cmpa_q == {$past(tmp_q), $past(wdata)})); // R3
  AST_LO_WRITE_KEEPS_TEMP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !addr[0]) |=> $stable(tmp_q)); // R3
  AST_CNT_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && !wr_en && addr == 3'd0) |=> (tmp_q == $past(cnt_q[2*BYTE_W-1:BYTE_W]))); // R4
  AST_CMP_READ_KEEPS_TEMP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && !wr_en && (addr[2:1] == 2'd1 || addr[2:1] == 2'd2)) |=> $stable(tmp_q)); // R5
  AST_HI_READ_TEMP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && (addr == 3'd1 || addr == 3'd7)) |-> (rdata == tmp_q)); // R6
  AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == 3'd0) |=> (cnt_q == {$past(tmp_q), $past(wdata)})); // R7
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |-> (rdata == '0)); // R9
endmodule

bind wide_reg_bridge wrb_checker #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .addr(addr), .wr_en(wr_en),
  .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .ld_stb(ld_stb),
  .tmp_q(tmp_q), .cnt_q(cnt_q), .cmpa_q(cmpa_q)
);

// File: tb/wide_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module wide_reg_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  addr;
  logic        wr_en, rd_en, cnt_en, cnt_clr, cap_evt;
  logic [7:0]  wdata, rdata;
  logic [3:0]  ld_stb;
  logic [15:0] ld_data, cnt_q, cmpa_q, cmpb_q, cap_q;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // behavioural reference state
  int m_tmp, m_cnt, m_cmpa, m_cmpb, m_cap;

  always #2 clk = ~clk;

  wide_reg_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
    .cap_evt(cap_evt), .ld_stb(ld_stb), .ld_data(ld_data), .cnt_q(cnt_q),
    .cmpa_q(cmpa_q), .cmpb_q(cmpb_q), .cap_q(cap_q)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int mget(input int t);
    case (t)
      0: return m_cnt;
      1: return m_cmpa;
      2: return m_cmpb;
      default: return m_cap;
    endcase
  endfunction

  task automatic model_reset();
    m_tmp = 0; m_cnt = 0; m_cmpa = 0; m_cmpb = 0; m_cap = 0;
  endtask

  task automatic check_regs(input string req);
    check(req, "cnt_q",  int'(cnt_q),  m_cnt);
    check(req, "cmpa_q", int'(cmpa_q), m_cmpa);
    check(req, "cmpb_q", int'(cmpb_q), m_cmpb);
    check(req, "cap_q",  int'(cap_q),  m_cap);
  endtask

  task automatic step(input int a, input bit w, input bit r, input int d,
                      input bit en, input bit clr, input bit cev, input string req);
    int t, sel, exp_rd, exp_ld, n_tmp, n_cnt, n_cap;
    bit hi;
    @(negedge clk);
    addr = 3'(a); wr_en = w; rd_en = r; wdata = 8'(d);
    cnt_en = en; cnt_clr = clr; cap_evt = cev;
    #1;
    t = a >> 1; hi = a[0]; sel = mget(t);
    if (!r)                   exp_rd = 0;
    else if (!hi)             exp_rd = sel & 255;
    else if (t == 1 || t == 2) exp_rd = sel >> 8;
    else                      exp_rd = m_tmp;
    exp_ld = (w && !hi) ? (1 << t) : 0;
    check(req, "rdata", int'(rdata), exp_rd);
    check(req, "ld_stb", int'(ld_stb), exp_ld);
    check(req, "ld_data", int'(ld_data), (m_tmp << 8) | (d & 255));
    // next model state, all from pre-edge values
    n_tmp = m_tmp;
    if (w && hi) n_tmp = d & 255;
    else if (r && !w && !hi && (t == 0 || t == 3)) n_tmp = sel >> 8;
    n_cnt = m_cnt;
    if (w && !hi && t == 0) n_cnt = (m_tmp << 8) | (d & 255);
    else if (clr)           n_cnt = 0;
    else if (en)            n_cnt = (m_cnt + 1) & 16'hFFFF;
    n_cap = m_cap;
    if (w && !hi && t == 3) n_cap = (m_tmp << 8) | (d & 255);
    else if (cev)           n_cap = m_cnt;
    if (w && !hi && t == 1) m_cmpa = (m_tmp << 8) | (d & 255);
    if (w && !hi && t == 2) m_cmpb = (m_tmp << 8) | (d & 255);
    m_tmp = n_tmp; m_cnt = n_cnt; m_cap = n_cap;
    @(posedge clk); #1;
    check_regs(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; addr = '0; wr_en = 0; rd_en = 0; wdata = '0;
    cnt_en = 0; cnt_clr = 0; cap_evt = 0;
    model_reset();
    repeat (2) @(posedge clk);
    #1; check_regs("R1");
    @(negedge clk); rst_n = 1'b1;
    idle(4, "R1");

    // R2 / R3: shared upper byte, reused for two compare loads
    step(3, 1, 0, 8'h12, 0, 0, 0, "R2");
    step(2, 1, 0, 8'h34, 0, 0, 0, "R3");
    step(4, 1, 0, 8'h56, 0, 0, 0, "R3");
    step(5, 1, 0, 8'hAB, 0, 0, 0, "R2");
    step(5, 0, 1, 0, 0, 0, 0, "R5");
    step(3, 0, 1, 0, 0, 0, 0, "R5");
    step(2, 0, 1, 0, 0, 0, 0, "R5");
    step(1, 0, 1, 0, 0, 0, 0, "R6");

    // R7: counter load, count, snapshot while running
    step(1, 1, 0, 8'h01, 0, 0, 0, "R7");
    step(0, 1, 0, 8'hFE, 1, 1, 0, "R7");
    step(0, 0, 0, 0, 1, 0, 0, "R7");
    step(0, 0, 1, 0, 1, 0, 0, "R4");
    step(1, 0, 1, 0, 1, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 1, 0, "R7");
    step(1, 1, 0, 8'hFF, 0, 0, 0, "R7");
    step(0, 1, 0, 8'hFF, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 0, 0, "R7");

    // R8: capture event and write priority
    idle(1, "R8");
    step(0, 0, 0, 0, 1, 0, 1, "R8");
    step(6, 0, 1, 0, 1, 0, 0, "R8");
    step(7, 0, 1, 0, 0, 0, 0, "R8");
    step(7, 1, 0, 8'h9C, 0, 0, 0, "R8");
    step(6, 1, 0, 8'h3D, 1, 0, 1, "R8");
    step(3, 0, 1, 0, 0, 0, 0, "R5");

    // R9: idle read zero, write and read together
    step(2, 0, 0, 0, 0, 0, 0, "R9");
    step(1, 1, 1, 8'h77, 0, 0, 0, "R9");
    step(0, 1, 1, 8'h11, 0, 0, 0, "R9");
    step(1, 0, 1, 0, 0, 0, 0, "R9");

    // R10: pseudo-random traffic over the whole map
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(int'(lf[2:0]), lf[3], lf[4], int'(lf[12:5]), lf[13],
           lf[15] & lf[14] & lf[1], lf[15] & lf[0], "R10");
    end

    // R1: asynchronous reset in mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    model_reset();
    check_regs("R1");
    @(negedge clk); rst_n = 1'b1;
    idle(3, "R1");
    step(1, 0, 1, 0, 0, 0, 0, "R1");

    done = 1;
    summary();
    $finish;
  end
endmodule